// File: doc/BRIEF.md
# USB Device Transaction Protocol Engine

This block is the control state machine of a simple full-speed USB device function. It receives already decoded token packets, data-packet bytes and handshake packets from a packet disassembler. It writes OUT and SETUP payloads into an external 256-byte buffer and feeds IN payloads from that buffer to a packet assembler. It also decides when to ask the assembler for an ACK handshake.

A byte-wise CRC16 runs over every received data packet. A payload is kept only when the CRC residual and the error strobes are clean; otherwise the write pointer returns to where the packet began. A programmable 16-bit timer limits how long the engine waits for an OUT/SETUP data packet and for the host's ACK after IN data. An IN request that finds the buffer empty is reported as an overrun. Start-of-frame tokens take a one-cycle detour through a special state.

Top module: `usbx_engine`

## Requirements
- R1: After a synchronous active-low reset the engine is idle. Every output strobe (`mem_we`, `asm_ack`, `asm_dvalid`, `asm_dlast`, `sof_seen` and all `err_*`) is low, and the first accepted payload byte is written at buffer address 0.
- R2: A token strobe with `tok_err` high, or with a PID outside {OUT=4'b0001, IN=4'b1001, SETUP=4'b1101, SOF=4'b0101}, gives a one-cycle `err_token` pulse and leaves the engine idle. An OUT, IN or SETUP token whose `tok_addr` differs from `dev_addr` is ignored: the data that follows writes nothing and draws no handshake. At most one `err_*` output is high in any cycle.
- R3: During an OUT or SETUP cycle, every received byte, including the two CRC bytes, is written at consecutive buffer addresses that wrap modulo 256.
- R4: The CRC16 uses polynomial x^16+x^15+x^2+1, bit-reflected (0xA001), least significant bit first, with a start value of 0xFFFF. At `dat_end` the packet is good when the running value equals 0xB001 and at least two bytes arrived. A good packet raises `asm_ack` for one cycle, and the next packet starts right after the payload, so the CRC bytes are not kept.
- R5: A packet with a wrong CRC, or with `dat_err` seen at any time during it, gives an `err_crc` pulse and no `asm_ack`. The write pointer goes back to its value at the start of the packet.
- R6: An IN token presents the stored bytes in order on `asm_data` with `asm_dvalid`, one byte per cycle in which `asm_ready` is high. It presents at most MAX_PKT bytes (8 by default), and `asm_dlast` marks the final one.
- R7: An IN token that finds no stored bytes gives an `err_overrun` pulse and presents nothing.
- R8: An ACK handshake (`hs_pid`=4'b0010) after IN data consumes the bytes that were sent, so the next IN continues with the bytes after them.
- R9: If no ACK arrives within the timeout after IN data, `err_timeout` pulses, nothing is consumed, and the next IN presents the same bytes again.
- R10: After an accepted OUT/SETUP token with no data, `err_timeout` pulses exactly `tmo_limit`+1 clock edges after the edge that accepted the token. The write pointer stays where it was.
- R11: A valid SOF token, whatever its address, raises `sof_seen` for exactly one cycle, and the engine then accepts the next token normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 7 | Address assigned to this device |
| tmo_limit | input | 16 | Timeout length in cycles, captured at each timer load |
| tok_valid | input | 1 | One-cycle strobe: a token was decoded |
| tok_pid | input | 4 | PID of the token |
| tok_addr | input | 7 | Address field of the token |
| tok_err | input | 1 | Token failed its PID or CRC5 check |
| dat_valid | input | 1 | One-cycle strobe: a data-packet byte is on `dat_byte` |
| dat_byte | input | 8 | Data-packet byte, CRC bytes included |
| dat_end | input | 1 | One-cycle strobe: the data packet ended |
| dat_err | input | 1 | Receive error during the data packet |
| hs_valid | input | 1 | One-cycle strobe: a handshake packet was decoded |
| hs_pid | input | 4 | PID of the handshake |
| mem_we | output | 1 | Buffer write enable |
| mem_waddr | output | 8 | Buffer write address |
| mem_wdata | output | 8 | Buffer write data |
| mem_raddr | output | 8 | Buffer read address |
| mem_rdata | input | 8 | Buffer read data, combinational from `mem_raddr` |
| asm_ack | output | 1 | One-cycle request to send an ACK handshake |
| asm_dvalid | output | 1 | IN payload byte offered to the assembler |
| asm_data | output | 8 | IN payload byte |
| asm_dlast | output | 1 | Offered byte is the last of the packet |
| asm_ready | input | 1 | Assembler takes the offered byte this cycle |
| sof_seen | output | 1 | One-cycle pulse in the special-token state |
| err_token | output | 1 | Invalid token pulse |
| err_crc | output | 1 | Rejected data packet pulse |
| err_overrun | output | 1 | IN request with no stored data pulse |
| err_timeout | output | 1 | Data or ACK wait expired pulse |

## Verification
The hardest situation to reach is the IN retry: a timeout must strike after a partly throttled IN transfer, and the following IN must repeat exactly the bytes that were not acknowledged. Reaching it also needs the buffer pointers to have wrapped past address 255, and rejected packets to have left stale bytes in the buffer. The stimulus runs a long seeded random mix of good, corrupted and error-flagged OUT packets of random length with random gaps, and IN transactions that are either acknowledged or left to time out. The assembler's ready signal is throttled at random. A reference byte queue in the bench predicts every address and byte, so a wrong rollback or retry shows up as a content mismatch several transactions later.

// File: rtl/usbx_pkg.sv
// Shared constants and types for the USB transaction engine.
// Assumes 4-bit PIDs as decoded (check bits already stripped).
package usbx_pkg;
    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SOF   = 4'b0101;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_ACK   = 4'b0010;

    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_RESID  = 16'hB001;
    localparam logic [15:0] CRC_POLY_R = 16'hA001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPECIAL,
        ST_RX_WAIT,
        ST_RX_DATA,
        ST_TX_DATA,
        ST_TX_WAIT
    } xact_state_t;
endpackage

// File: rtl/usbx_crc16.sv
// Combinational CRC16 step over DW data bits, LSB first, reflected polynomial.
// Assumes the caller registers the running value between steps.
module usbx_crc16
    import usbx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [15:0]   crc_i,
    input  logic [DW-1:0] data_i,
    output logic [15:0]   crc_o
);
    logic [15:0] stage [0:DW];

    assign stage[0] = crc_i;

    // One shift-and-conditional-xor per data bit
    generate
        for (genvar b = 0; b < DW; b++) begin : g_bit
            logic fb;
            assign fb = stage[b][0] ^ data_i[b];
            assign stage[b+1] = fb ? ((stage[b] >> 1) ^ CRC_POLY_R) : (stage[b] >> 1);
        end
    endgenerate

    assign crc_o = stage[DW];
endmodule

// File: rtl/usbx_timer.sv
// Up-counting timeout timer. load clears the count and captures the limit;
// the count advances while en is high and timeout is raised when it equals
// the limit. Assumes the owner drops en after it sees the timeout.
module usbx_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] limit,
    input  logic          en,
    output logic          timeout
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim_q;

    // Count and limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            lim_q <= limit;
        end else if (en && (cnt_q != lim_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry flag
    assign timeout = en && (cnt_q == lim_q);
endmodule

// File: rtl/usbx_engine.sv
// USB device transaction protocol engine. Dispatches decoded tokens, stores
// OUT/SETUP payloads with CRC16 check and rollback, serves IN payloads with
// ACK-or-timeout retry. Assumes an external 256-byte buffer with
// combinational read and that the host never stores more than the buffer holds.
module usbx_engine
    import usbx_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int MAX_PKT = 8,
    parameter int TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        dev_addr,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              tok_valid,
    input  logic [3:0]        tok_pid,
    input  logic [6:0]        tok_addr,
    input  logic              tok_err,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    input  logic              dat_end,
    input  logic              dat_err,
    input  logic              hs_valid,
    input  logic [3:0]        hs_pid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              asm_ack,
    output logic              asm_dvalid,
    output logic [7:0]        asm_data,
    output logic              asm_dlast,
    input  logic              asm_ready,
    output logic              sof_seen,
    output logic              err_token,
    output logic              err_crc,
    output logic              err_overrun,
    output logic              err_timeout
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int CNT_W = $clog2(MAX_PKT + 1);
    localparam logic [PTR_W-1:0] MAXP = PTR_W'(MAX_PKT);

    xact_state_t       st_q;
    logic [PTR_W-1:0]  wr_q, rd_q, start_q, tx_q;
    logic [CNT_W-1:0]  txcnt_q;
    logic [15:0]       crc_q, crc_nxt;
    logic              rxbad_q;
    logic              ack_q, etok_q, ecrc_q, eovr_q, etmo_q;

    logic              in_rx, tok_known, addr_hit, is_rx_tok;
    logic              tmo, tmr_load, tmr_en;
    logic [PTR_W-1:0]  avail, rx_len;
    logic [CNT_W-1:0]  first_len;
    logic              pkt_good;

    // Byte-wise CRC16 over received data
    usbx_crc16 #(.DW(8)) u_crc (
        .crc_i (crc_q),
        .data_i(dat_byte),
        .crc_o (crc_nxt)
    );

    // Wait-state timeout
    usbx_timer #(.TW(TMO_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .limit  (tmo_limit),
        .en     (tmr_en),
        .timeout(tmo)
    );

    // Token classification and length arithmetic
    always_comb begin
        tok_known = (tok_pid == PID_OUT) || (tok_pid == PID_IN) ||
                    (tok_pid == PID_SETUP) || (tok_pid == PID_SOF);
        addr_hit  = (tok_addr == dev_addr);
        is_rx_tok = (tok_pid == PID_OUT) || (tok_pid == PID_SETUP);
        in_rx     = (st_q == ST_RX_WAIT) || (st_q == ST_RX_DATA);
        avail     = wr_q - rd_q;
        rx_len    = wr_q - start_q;
        first_len = (avail > MAXP) ? CNT_W'(MAX_PKT) : CNT_W'(avail);
        pkt_good  = !rxbad_q && !dat_err && (crc_q == CRC_RESID) && (rx_len >= PTR_W'(2));
    end

    // Timer control: load on entry to a wait, count only while waiting
    always_comb begin
        tmr_load = ((st_q == ST_IDLE) && tok_valid && !tok_err && tok_known &&
                    is_rx_tok && addr_hit) ||
                   ((st_q == ST_TX_DATA) && asm_ready && (txcnt_q == CNT_W'(1)));
        tmr_en   = in_rx || (st_q == ST_TX_WAIT);
    end

    // Main transaction state machine with pointers and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            wr_q    <= '0;
            rd_q    <= '0;
            start_q <= '0;
            tx_q    <= '0;
            txcnt_q <= '0;
            crc_q   <= CRC_INIT;
            rxbad_q <= 1'b0;
            ack_q   <= 1'b0;
            etok_q  <= 1'b0;
            ecrc_q  <= 1'b0;
            eovr_q  <= 1'b0;
            etmo_q  <= 1'b0;
        end else begin
            ack_q  <= 1'b0;
            etok_q <= 1'b0;
            ecrc_q <= 1'b0;
            eovr_q <= 1'b0;
            etmo_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (tok_valid) begin
                        if (tok_err || !tok_known) begin
                            etok_q <= 1'b1;
                        end else if (tok_pid == PID_SOF) begin
                            st_q <= ST_SPECIAL;
                        end else if (addr_hit) begin
                            if (is_rx_tok) begin
                                st_q    <= ST_RX_WAIT;
                                start_q <= wr_q;
                                crc_q   <= CRC_INIT;
                                rxbad_q <= 1'b0;
                            end else if (avail == '0) begin
                                eovr_q <= 1'b1;
                            end else begin
                                st_q    <= ST_TX_DATA;
                                tx_q    <= rd_q;
                                txcnt_q <= first_len;
                            end
                        end
                    end
                end
                ST_SPECIAL: st_q <= ST_IDLE;
                ST_RX_WAIT, ST_RX_DATA: begin
                    if (tmo) begin
                        wr_q   <= start_q;
                        etmo_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else if (dat_valid) begin
                        wr_q  <= wr_q + 1'b1;
                        crc_q <= crc_nxt;
                        st_q  <= ST_RX_DATA;
                        if (dat_err) rxbad_q <= 1'b1;
                    end else if (dat_end) begin
                        if (pkt_good) begin
                            wr_q  <= wr_q - PTR_W'(2);
                            ack_q <= 1'b1;
                        end else begin
                            wr_q   <= start_q;
                            ecrc_q <= 1'b1;
                        end
                        st_q <= ST_IDLE;
                    end else if (dat_err) begin
                        rxbad_q <= 1'b1;
                    end
                end
                ST_TX_DATA: begin
                    if (asm_ready) begin
                        tx_q    <= tx_q + 1'b1;
                        txcnt_q <= txcnt_q - 1'b1;
                        if (txcnt_q == CNT_W'(1)) st_q <= ST_TX_WAIT;
                    end
                end
                ST_TX_WAIT: begin
                    if (hs_valid && (hs_pid == PID_ACK)) begin
                        rd_q <= tx_q;
                        st_q <= ST_IDLE;
                    end else if (tmo) begin
                        etmo_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Buffer and assembler side outputs
    always_comb begin
        mem_we      = in_rx && dat_valid && !tmo;
        mem_waddr   = wr_q[ADDR_W-1:0];
        mem_wdata   = dat_byte;
        mem_raddr   = tx_q[ADDR_W-1:0];
        asm_dvalid  = (st_q == ST_TX_DATA);
        asm_data    = mem_rdata;
        asm_dlast   = asm_dvalid && (txcnt_q == CNT_W'(1));
        sof_seen    = (st_q == ST_SPECIAL);
        asm_ack     = ack_q;
        err_token   = etok_q;
        err_crc     = ecrc_q;
        err_overrun = eovr_q;
        err_timeout = etmo_q;
    end
endmodule

// File: rtl/usbx_engine_chk.sv
// Port-level assertion checker for usbx_engine, attached by bind.
module usbx_engine_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic [3:0]        tok_pid,
    input logic              dat_end,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic              asm_ack,
    input logic              asm_dvalid,
    input logic              asm_dlast,
    input logic              asm_ready,
    input logic              sof_seen,
    input logic              err_token,
    input logic              err_crc,
    input logic              err_overrun,
    input logic              err_timeout
);
    p_err_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_token, err_crc, err_overrun, err_timeout}));

    p_we_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + 1'b1));

    p_ack_after_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        asm_ack |-> $past(dat_end));

    p_ack_not_crc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(asm_ack && err_crc));

    p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        asm_dlast |-> asm_dvalid);

    p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (asm_dvalid && !asm_ready) |=> asm_dvalid);

    p_no_write_in_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        asm_dvalid |-> !mem_we);

    p_overrun_from_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |-> ($past(tok_valid) && ($past(tok_pid) == 4'b1001)));

    p_sof_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sof_seen |=> !sof_seen);
endmodule

bind usbx_engine usbx_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_valid  (tok_valid),
    .tok_pid    (tok_pid),
    .dat_end    (dat_end),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .asm_ack    (asm_ack),
    .asm_dvalid (asm_dvalid),
    .asm_dlast  (asm_dlast),
    .asm_ready  (asm_ready),
    .sof_seen   (sof_seen),
    .err_token  (err_token),
    .err_crc    (err_crc),
    .err_overrun(err_overrun),
    .err_timeout(err_timeout)
);

// File: tb/sim_usbx_engine.sv
// Self-checking bench: directed corner cases, then a seeded random mix.
module sim_usbx_engine;
    localparam int TMO   = 100;
    localparam logic [6:0] DEV = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] tok_pid = '0, hs_pid = '0;
    logic [6:0] tok_addr = '0;
    logic tok_valid = 0, tok_err = 0, dat_valid = 0, dat_end = 0, dat_err = 0;
    logic hs_valid = 0, asm_ready = 0;
    logic [7:0] dat_byte = '0;
    logic mem_we, asm_ack, asm_dvalid, asm_dlast, sof_seen;
    logic err_token, err_crc, err_overrun, err_timeout;
    logic [7:0] mem_waddr, mem_wdata, mem_raddr, mem_rdata, asm_data;

    always #5 clk = ~clk;

    usbx_engine u0 (
        .clk(clk), .rst_n(rst_n), .dev_addr(DEV), .tmo_limit(16'(TMO)),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_err(tok_err),
        .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_end(dat_end), .dat_err(dat_err),
        .hs_valid(hs_valid), .hs_pid(hs_pid),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .asm_ack(asm_ack), .asm_dvalid(asm_dvalid), .asm_data(asm_data),
        .asm_dlast(asm_dlast), .asm_ready(asm_ready), .sof_seen(sof_seen),
        .err_token(err_token), .err_crc(err_crc), .err_overrun(err_overrun),
        .err_timeout(err_timeout)
    );

    // External buffer model
    logic [7:0] ram [0:255];
    assign mem_rdata = ram[mem_raddr];
    always @(posedge clk) if (mem_we) ram[mem_waddr] <= mem_wdata;

    // Event counters
    int n_ack = 0, n_tok = 0, n_crc = 0, n_ovr = 0, n_tmo = 0, n_sof = 0, n_we = 0;
    logic [7:0] last_wa = '0;
    always @(posedge clk) if (rst_n) begin
        n_ack <= n_ack + int'(asm_ack);
        n_tok <= n_tok + int'(err_token);
        n_crc <= n_crc + int'(err_crc);
        n_ovr <= n_ovr + int'(err_overrun);
        n_tmo <= n_tmo + int'(err_timeout);
        n_sof <= n_sof + int'(sof_seen);
        if (mem_we) begin
            n_we <= n_we + 1;
            last_wa <= mem_waddr;
        end
    end

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] ref_mem [0:255];
    int ref_wr = 0, ref_rd = 0;
    logic [7:0] pl [0:63];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic token(input logic [3:0] pid, input logic [6:0] a, input bit e);
        @(negedge clk);
        tok_valid = 1; tok_pid = pid; tok_addr = a; tok_err = e;
        @(negedge clk);
        tok_valid = 0; tok_err = 0;
    endtask

    // mode 0 good, 1 corrupted CRC, 2 receive error on first byte
    task automatic send_pkt(input int n, input int mode);
        logic [15:0] c;
        logic [7:0] b;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) c = crc_byte(c, pl[i]);
        for (int i = 0; i < n + 2; i++) begin
            b = (i < n) ? pl[i] : ((i == n) ? ~c[7:0] : ~c[15:8]);
            if (mode == 1 && i == n + 1) b = b ^ 8'h01;
            @(negedge clk);
            dat_valid = 1; dat_byte = b; dat_err = (mode == 2 && i == 0);
            @(negedge clk);
            dat_valid = 0; dat_err = 0;
            wait_n($urandom % 3);
        end
        @(negedge clk); dat_end = 1;
        @(negedge clk); dat_end = 0;
        wait_n(3);
    endtask

    task automatic out_xact(input int n, input int mode, input string tag);
        int a0, w0, c0, wd;
        a0 = n_ack; w0 = n_we; c0 = n_crc;
        for (int i = 0; i < n; i++) pl[i] = 8'($urandom);
        token(($urandom % 2) ? 4'b0001 : 4'b1101, DEV, 0);
        send_pkt(n, mode);
        wd = n_we - w0;
        chk(wd == n + 2, {tag, " R3 write count"}, wd, n + 2);
        chk(int'(8'(last_wa - 8'(wd - 1))) == (ref_wr % 256), {tag, " R3 start address"},
            int'(8'(last_wa - 8'(wd - 1))), ref_wr % 256);
        if (mode == 0) begin
            chk(n_ack - a0 == 1 && n_crc == c0, {tag, " R4 ack on good packet"}, n_ack - a0, 1);
            for (int i = 0; i < n; i++) ref_mem[(ref_wr + i) % 256] = pl[i];
            ref_wr += n;
        end else begin
            chk(n_ack == a0 && n_crc - c0 == 1, {tag, " R5 reject bad packet"}, n_crc - c0, 1);
        end
    endtask

    task automatic in_xact(input bit do_ack, input string tag);
        int exp_n, got, o0, t0, mism;
        bit fin, r, last_ok;
        exp_n = ref_wr - ref_rd;
        if (exp_n > 8) exp_n = 8;
        o0 = n_ovr; t0 = n_tmo;
        token(4'b1001, DEV, 0);
        if (exp_n == 0) begin
            got = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (asm_dvalid) got++;
            end
            chk(n_ovr - o0 == 1 && got == 0, {tag, " R7 overrun"}, n_ovr - o0, 1);
            return;
        end
        got = 0; fin = 0; mism = 0; last_ok = 1;
        for (int g = 0; g < 400 && !fin; g++) begin
            @(negedge clk);
            r = ($urandom % 3) != 0;
            if (asm_dvalid && r) begin
                if (asm_data != ref_mem[(ref_rd + got) % 256]) mism++;
                if (asm_dlast != (got == exp_n - 1)) last_ok = 0;
                got++;
                if (asm_dlast) fin = 1;
            end
            asm_ready = r;
        end
        @(negedge clk); asm_ready = 0;
        chk(got == exp_n, {tag, " R6 byte count"}, got, exp_n);
        chk(mism == 0, {tag, " R6 byte content"}, mism, 0);
        chk(last_ok, {tag, " R6 last flag"}, int'(last_ok), 1);
        if (do_ack) begin
            hs_valid = 1; hs_pid = 4'b0010;
            @(negedge clk); hs_valid = 0;
            wait_n(3);
            chk(n_tmo == t0, {tag, " R8 no timeout after ack"}, n_tmo - t0, 0);
            ref_rd += exp_n;
        end else begin
            wait_n(TMO + 6);
            chk(n_tmo - t0 == 1, {tag, " R9 ack timeout"}, n_tmo - t0, 1);
        end
    endtask

    initial begin
        int c0, w0, first, ph;
        void'($urandom(32'd1347));
        wait_n(3);
        // R1: reset state
        chk({mem_we, asm_ack, asm_dvalid, asm_dlast, sof_seen, err_token, err_crc,
             err_overrun, err_timeout} == '0, "R1 outputs quiet in reset", 1, 0);
        @(negedge clk); rst_n = 1;
        wait_n(2);
        chk({mem_we, asm_ack, asm_dvalid, sof_seen, err_token, err_timeout} == '0,
            "R1 outputs quiet after reset", 1, 0);

        // R11: SOF with foreign address
        c0 = n_sof;
        token(4'b0101, 7'h11, 0);
        wait_n(3);
        chk(n_sof - c0 == 1, "R11 sof pulse", n_sof - c0, 1);

        // R2: invalid PID, token error, foreign address
        c0 = n_tok;
        token(4'b0011, DEV, 0);
        wait_n(2);
        chk(n_tok - c0 == 1, "R2 unknown pid", n_tok - c0, 1);
        token(4'b0001, DEV, 1);
        wait_n(2);
        chk(n_tok - c0 == 2, "R2 token error", n_tok - c0, 2);
        c0 = n_ack; w0 = n_we;
        for (int i = 0; i < 4; i++) pl[i] = 8'(i + 1);
        token(4'b0001, 7'h05, 0);
        send_pkt(4, 0);
        chk(n_we == w0 && n_ack == c0, "R2 foreign address ignored", n_we - w0, 0);

        // R7: IN on empty buffer
        in_xact(1, "empty");

        // R4: zero-length packet, then first payload at address 0 (R1)
        out_xact(0, 0, "zero length");
        out_xact(5, 0, "R1 first packet");
        // R5: bad CRC and receive error roll back
        out_xact(7, 1, "bad crc");
        out_xact(6, 2, "rx error");
        out_xact(3, 0, "after rollback");
        // R6 cap at 8 bytes and R8 consume
        in_xact(1, "cap eight");
        in_xact(1, "remainder");

        // R10: data wait timeout timing
        c0 = n_tmo;
        @(negedge clk); tok_valid = 1; tok_pid = 4'b0001; tok_addr = DEV;
        @(negedge clk); tok_valid = 0;
        first = 0;
        for (int i = 1; i <= TMO + 5; i++) begin
            @(negedge clk);
            if (err_timeout && first == 0) first = i;
        end
        chk(first == TMO + 1, "R10 data timeout cycle", first, TMO + 1);
        out_xact(4, 0, "R10 pointer kept");

        // R9: IN timeout then retry
        in_xact(0, "retry first");
        in_xact(1, "retry second");

        // Random mix; pointers wrap past 255 (R3)
        for (int it = 0; it < 160; it++) begin
            ph = $urandom % 100;
            if (ref_wr - ref_rd > 180) ph = 70;
            if (ph < 45)      out_xact(1 + ($urandom % 20), 0, "rand good");
            else if (ph < 55) out_xact($urandom % 12, 1, "rand crc");
            else if (ph < 60) out_xact($urandom % 12, 2, "rand rxerr");
            else if (ph < 90) in_xact(1, "rand in ack");
            else              in_xact(0, "rand in tmo");
        end
        chk(ref_wr > 256, "R3 wrap reached", ref_wr, 257);
        while (ref_wr != ref_rd) in_xact(1, "drain");
        in_xact(1, "final empty");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule